// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block is the capture sequencer of an on-chip logic analyzer. A host drives it through a plain register bus: one write per cycle and one read address per cycle. It writes one probe sample per clock into a circular sample memory. It first stores a programmable number of samples that come before the trigger. It then keeps overwriting the oldest samples while it waits for a single-cycle trigger pulse from separate comparison logic. After the trigger it fills the rest of the buffer and stops.

A capture begins on a rising edge of a start register bit and ends early on a rising edge of a stop register bit. When the capture is done, a read-pointer register holds the buffer index of the oldest sample. The host rotates the buffer so that this index comes first, and the samples are then in time order. The sample memory appears on the same bus at a parameterised base address, one address per sample.

Top module: `capture_ctrl`

## Requirements
- R1: After reset, the state, trigger-location, current-location, start, stop and read-pointer registers all read 0.
- R2: The register window starts at REG_BASE with these offsets: state at +0, trigger location at +1, current location at +2, start at +3, stop at +4, read pointer at +5. Sample i is at SAMPLE_BASE+i. A read returns its data one cycle after the address is presented. The state codes are idle 0, pre-fill 1, armed 2, post-fill 3 and done 4.
- R3: A write that takes the start bit (bit 0) from 0 to 1 while idle starts a capture. The state goes to pre-fill, or to armed if the trigger location is 0, and the write address goes to 0. Writing 1 when the bit is already 1 does nothing. A start edge in any state other than idle is ignored.
- R4: A write that takes the stop bit (bit 0) from 0 to 1 puts the state to idle from any state on the next cycle. If it falls in the same cycle as a trigger that would finish the capture, the stop wins: no sample is written and the read pointer is unchanged.
- R5: In pre-fill, one sample is written per clock until trigger-location samples are stored, and then the state becomes armed. A trigger in pre-fill is ignored.
- R6: In armed, samples keep being written circularly. A trigger starts post-fill. The sample taken in the trigger cycle is the first of DEPTH minus trigger-location post-trigger samples. After rotation by the read pointer, the buffer holds consecutive samples with the trigger sample at index trigger-location.
- R7: After the last post-trigger sample the state becomes done and stays done until a stop edge. The read pointer and the current location both equal the total number of samples written, modulo DEPTH.
- R8: Writes to the state, current-location and read-pointer registers are ignored. The trigger location changes only on a write made while idle whose value is below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | BUS_W | Register bus write data |
| bus_rdata | output | BUS_W | Read data for the address of the previous cycle |
| probe_in | input | DATA_W | Probe sample stored each capture cycle |
| trig_in | input | 1 | Trigger pulse from the trigger logic |

## Verification
Two events can fall in the same clock: a stop edge written by the host, and the trigger that would finish a capture. This happens when the trigger location is DEPTH-1, because then only one post-trigger sample is needed. The bench arms such a capture and drives the trigger pulse and the stop write on the same edge. It then expects the state to read idle and the read pointer to keep its old value, instead of done with a newly loaded pointer. Each capture is judged by rotating the buffer read over the bus. The rotated buffer must hold consecutive probe values, with the trigger-cycle value at the trigger location.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MOVE  = 3'd1,
        ST_INPOS = 3'd2,
        ST_CAPT  = 3'd3,
        ST_DONE  = 3'd4
    } cap_state_t;

    localparam int OFS_STATE = 0;
    localparam int OFS_TLOC  = 1;
    localparam int OFS_CUR   = 2;
    localparam int OFS_START = 3;
    localparam int OFS_STOP  = 4;
    localparam int OFS_RDPTR = 5;
endpackage

// File: rtl/cap_mem.sv
module cap_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/cap_regs.sv
module cap_regs
    import cap_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int BUS_W       = 16,
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 16,
    parameter int REG_BASE    = 0,
    parameter int SAMPLE_BASE = 8,
    localparam int PTR_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  cap_state_t        state,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PTR_W-1:0]  mem_raddr,
    output logic [PTR_W-1:0]  trig_loc,
    output logic              start_req,
    output logic              stop_req
);
    localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(REG_BASE + OFS_STATE);
    localparam logic [ADDR_W-1:0] A_TLOC  = ADDR_W'(REG_BASE + OFS_TLOC);
    localparam logic [ADDR_W-1:0] A_CUR   = ADDR_W'(REG_BASE + OFS_CUR);
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(REG_BASE + OFS_START);
    localparam logic [ADDR_W-1:0] A_STOP  = ADDR_W'(REG_BASE + OFS_STOP);
    localparam logic [ADDR_W-1:0] A_RDPTR = ADDR_W'(REG_BASE + OFS_RDPTR);
    localparam logic [ADDR_W-1:0] A_SBASE = ADDR_W'(SAMPLE_BASE);
    localparam logic [ADDR_W:0]   A_SEND  = (ADDR_W+1)'(SAMPLE_BASE + DEPTH);
    localparam logic [BUS_W-1:0]  TLOC_LIM = BUS_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] tloc;
        logic             start;
        logic             stop;
        logic [BUS_W-1:0] rdata;
    } regs_t;

    regs_t q, d;
    logic  in_mem;

    always_comb begin
        d         = q;
        start_req = 1'b0;
        stop_req  = 1'b0;
        in_mem    = (bus_addr >= A_SBASE) && ({1'b0, bus_addr} < A_SEND);
        mem_raddr = PTR_W'(bus_addr - A_SBASE);

        if (bus_we && bus_addr == A_START) begin
            start_req = bus_wdata[0] && !q.start;
            d.start   = bus_wdata[0];
        end
        if (bus_we && bus_addr == A_STOP) begin
            stop_req = bus_wdata[0] && !q.stop;
            d.stop   = bus_wdata[0];
        end
        if (bus_we && bus_addr == A_TLOC && state == ST_IDLE && bus_wdata < TLOC_LIM)
            d.tloc = PTR_W'(bus_wdata);

        if (in_mem)                  d.rdata = BUS_W'(mem_rdata);
        else if (bus_addr == A_STATE) d.rdata = BUS_W'(state);
        else if (bus_addr == A_TLOC)  d.rdata = BUS_W'(q.tloc);
        else if (bus_addr == A_CUR)   d.rdata = BUS_W'(wr_ptr);
        else if (bus_addr == A_START) d.rdata = BUS_W'(q.start);
        else if (bus_addr == A_STOP)  d.rdata = BUS_W'(q.stop);
        else if (bus_addr == A_RDPTR) d.rdata = BUS_W'(rd_ptr);
        else                          d.rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign bus_rdata = q.rdata;
    assign trig_loc  = q.tloc;
endmodule

// File: rtl/cap_fsm.sv
module cap_fsm
    import cap_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_in,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic [PTR_W-1:0] trig_loc,
    output cap_state_t       state,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             mem_we
);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);

    typedef struct packed {
        cap_state_t       st;
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t q, d;
    logic [CNT_W-1:0] post_len;
    logic [PTR_W-1:0] wr_inc;

    always_comb begin
        d        = q;
        mem_we   = 1'b0;
        post_len = FULL - {1'b0, trig_loc};
        wr_inc   = (q.wr == LAST) ? '0 : q.wr + PTR_W'(1);

        case (q.st)
            ST_IDLE: begin
                if (start_req) begin
                    d.wr  = '0;
                    d.cnt = '0;
                    d.st  = (trig_loc == '0) ? ST_INPOS : ST_MOVE;
                end
            end
            ST_MOVE: begin
                mem_we = 1'b1;
                d.wr   = wr_inc;
                d.cnt  = q.cnt + ONE;
                if (q.cnt + ONE == {1'b0, trig_loc}) d.st = ST_INPOS;
            end
            ST_INPOS: begin
                mem_we = 1'b1;
                d.wr   = wr_inc;
                if (trig_in) begin
                    d.cnt = ONE;
                    if (post_len == ONE) begin
                        d.st = ST_DONE;
                        d.rd = wr_inc;
                    end else begin
                        d.st = ST_CAPT;
                    end
                end
            end
            ST_CAPT: begin
                mem_we = 1'b1;
                d.wr   = wr_inc;
                d.cnt  = q.cnt + ONE;
                if (q.cnt + ONE == post_len) begin
                    d.st = ST_DONE;
                    d.rd = wr_inc;
                end
            end
            default: ;
        endcase

        if (stop_req) begin
            d      = q;
            d.st   = ST_IDLE;
            mem_we = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st  <= ST_IDLE;
            q.wr  <= '0;
            q.rd  <= '0;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign state  = q.st;
    assign wr_ptr = q.wr;
    assign rd_ptr = q.rd;
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
    import cap_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 16,
    parameter int ADDR_W      = 8,
    parameter int BUS_W       = 16,
    parameter int REG_BASE    = 0,
    parameter int SAMPLE_BASE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0] probe_in,
    input  logic              trig_in
);
    localparam int PTR_W = $clog2(DEPTH);

    cap_state_t        state_w;
    logic [PTR_W-1:0]  wr_ptr_w, rd_ptr_w, trig_loc_w, mem_raddr_w;
    logic [DATA_W-1:0] mem_rdata_w;
    logic              start_req_w, stop_req_w, mem_we_w;

    cap_regs #(
        .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
        .REG_BASE(REG_BASE), .SAMPLE_BASE(SAMPLE_BASE)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .state(state_w), .wr_ptr(wr_ptr_w), .rd_ptr(rd_ptr_w),
        .mem_rdata(mem_rdata_w), .mem_raddr(mem_raddr_w),
        .trig_loc(trig_loc_w), .start_req(start_req_w), .stop_req(stop_req_w)
    );

    cap_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk(clk), .rst(rst), .trig_in(trig_in),
        .start_req(start_req_w), .stop_req(stop_req_w), .trig_loc(trig_loc_w),
        .state(state_w), .wr_ptr(wr_ptr_w), .rd_ptr(rd_ptr_w), .mem_we(mem_we_w)
    );

    cap_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(mem_we_w), .waddr(wr_ptr_w), .wdata(probe_in),
        .raddr(mem_raddr_w), .rdata(mem_rdata_w)
    );
endmodule

// File: rtl/cap_chk.sv
module cap_chk
    import cap_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input cap_state_t       state,
    input logic             start_req,
    input logic             stop_req,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] trig_loc
);
    // R2
    state_legal_chk: assert property (@(posedge clk) disable iff (rst)
        state inside {ST_IDLE, ST_MOVE, ST_INPOS, ST_CAPT, ST_DONE});

    // R3
    start_move_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start_req && !stop_req) |=> (state == ST_MOVE || state == ST_INPOS));

    // R4
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> state == ST_IDLE);

    // R5
    move_next_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MOVE && !stop_req) |=> (state == ST_MOVE || state == ST_INPOS));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && !stop_req) |=> state == ST_DONE);

    // R7
    rdptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_ptr) |-> (state == ST_DONE && $past(state) != ST_DONE));

    // R8
    tloc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(trig_loc) |-> $past(state) == ST_IDLE);
endmodule

bind capture_ctrl cap_chk #(.PTR_W(PTR_W)) u_cap_chk (
    .clk(clk), .rst(rst), .state(state_w), .start_req(start_req_w),
    .stop_req(stop_req_w), .rd_ptr(rd_ptr_w), .trig_loc(trig_loc_w)
);

// File: tb/tb_capture_ctrl.sv
module tb_capture_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = 8;
    localparam int BUS_W  = 16;
    localparam int SBASE  = 8;
    localparam int NCASE  = 4;
    // stimulus: trigger location; expected results are derived per case
    localparam int CASE_L [NCASE] = '{4, 0, 15, 9};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic [DATA_W-1:0] probe = '0;
    logic              trig = 1'b0;

    int checks = 0;
    int errors = 0;
    int last_probe = 0;
    int rbuf [DEPTH];

    capture_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BUS_W(BUS_W),
                   .REG_BASE(0), .SAMPLE_BASE(SBASE)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .probe_in(probe), .trig_in(trig)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) probe <= probe + 1'b1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk); #1;
        bus_addr = ADDR_W'(a); bus_wdata = BUS_W'(v); bus_we = 1'b1;
        last_probe = int'(probe);
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk); #1;
        bus_addr = ADDR_W'(a);
        @(negedge clk); #1;
        v = int'(bus_rdata);
    endtask

    task automatic stop_seq();
        wr(4, 0);
        wr(4, 1);
    endtask

    task automatic wait_state(input string req, input int s);
        int v = -1;
        for (int n = 0; n < 100 && v != s; n++) rd(0, v);
        check(req, v, s);
    endtask

    task automatic run_case(input int L);
        int first, t, exp_rd, got, bad;
        stop_seq();
        wr(1, L);
        rd(1, got);
        check("R8 trig location written while idle", got, L);
        wr(3, 1);
        first = (last_probe + 1) % 256;
        wr(3, 0);
        wait_state("R5 armed after pre-fill", 2);
        repeat (DEPTH + 2) @(negedge clk);
        #1 trig = 1'b1;
        t = int'(probe);
        @(negedge clk); #1 trig = 1'b0;
        wait_state("R7 done after post-fill", 4);
        exp_rd = ((t - first + 256) % 256 + (DEPTH - L)) % DEPTH;
        rd(5, got);
        check("R7 read pointer", got, exp_rd);
        rd(2, got);
        check("R7 current location equals read pointer", got, exp_rd);
        for (int i = 0; i < DEPTH; i++) rd(SBASE + i, rbuf[i]);
        check("R6 trigger sample at trigger location", rbuf[(exp_rd + L) % DEPTH], t);
        bad = 0;
        for (int i = 1; i < DEPTH; i++)
            if (rbuf[(exp_rd + i) % DEPTH] != (rbuf[(exp_rd + i - 1) % DEPTH] + 1) % 256) bad++;
        check("R6 rotated buffer consecutive", bad, 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, rp;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        rd(0, v); check("R1 state after reset", v, 0);
        rd(1, v); check("R1 trig location after reset", v, 0);
        rd(2, v); check("R1 current location after reset", v, 0);
        rd(3, v); check("R1 start after reset", v, 0);
        rd(4, v); check("R1 stop after reset", v, 0);
        rd(5, v); check("R1 read pointer after reset", v, 0);

        // table of captures (R2 map, R5, R6, R7)
        for (int k = 0; k < NCASE; k++) run_case(CASE_L[k]);

        // R3 start ignored while done
        rd(5, rp);
        wr(3, 1);
        rd(0, v); check("R3 start ignored when not idle", v, 4);
        rd(5, v); check("R3 read pointer kept on ignored start", v, rp);
        wr(3, 0);

        // R8 writes ignored
        wr(1, 2);
        rd(1, v); check("R8 trig location locked outside idle", v, 9);
        wr(0, 0);
        wr(5, (rp + 1) % DEPTH);
        wr(2, 1);
        rd(0, v); check("R8 state write ignored", v, 4);
        rd(5, v); check("R8 read pointer write ignored", v, rp);
        rd(2, v); check("R8 current location write ignored", v, rp);

        // R4 stop from done
        stop_seq();
        rd(0, v); check("R4 stop from done", v, 0);

        // R8 out of range location
        wr(1, DEPTH);
        rd(1, v); check("R8 location at DEPTH ignored", v, 9);

        // R5 trigger ignored in pre-fill
        wr(1, 12);
        wr(3, 1);
        trig = 1'b1;
        @(negedge clk); #1 trig = 1'b0;
        wr(3, 0);
        repeat (20) @(negedge clk);
        rd(0, v); check("R5 trigger in pre-fill ignored", v, 2);

        // R4 stop from armed
        stop_seq();
        rd(0, v); check("R4 stop from armed", v, 0);

        // R3 level held high does not restart
        wr(3, 1);
        rd(0, v); check("R3 start edge begins capture", v, 1);
        stop_seq();
        wr(3, 1);
        rd(0, v); check("R3 held start level no restart", v, 0);
        wr(3, 0);

        // R4 stop and completing trigger in the same cycle
        rd(5, rp);
        wr(1, 15);
        wr(3, 1);
        wr(3, 0);
        wait_state("R4 armed before collision", 2);
        wr(4, 0);
        repeat (DEPTH + 2) @(negedge clk);
        #1 trig = 1'b1;
        bus_addr = ADDR_W'(4); bus_wdata = BUS_W'(1); bus_we = 1'b1;
        @(negedge clk); #1 trig = 1'b0; bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rd(0, v); check("R4 stop wins over completion", v, 0);
        rd(5, v); check("R4 read pointer unchanged on collision", v, rp);

        finish_run();
    end
endmodule